// File: doc/BRIEF.md
# Tagged Branch Target Table

This block keeps a direct-mapped table of branch outcomes. Each entry holds a 2-bit status, a 16-bit tag and a 32-bit predicted target. Every cycle a lookup address is split into an index and a tag. One clock later the block returns the stored status and target, or zeros when there is nothing useful to return. A separate update port writes a whole entry at the index taken from its own address. What the status values mean belongs to the predictor that drives the update port and is not decided here.

The storage arrays have no reset of their own. After reset a small sequencer steps through the entries, one per clock, and writes zeros through the table's single write port. During this sweep lookups return zero and updates are dropped. When the last entry has been cleared a ready flag rises and the write port goes back to the update path.

Top module: `branchTargetTable`

## Requirements
- R1: While reset is held and on the first cycle after it, `ready` is 0 and both lookup outputs are 0.
- R2: After reset is released, `ready` stays 0 for DEPTH rising edges and is 1 from the DEPTH-th edge on, until the next reset.
- R3: An update presented while `ready` is 0 writes nothing. After the sweep, a lookup of that address returns zeros.
- R4: While `ready` is 0, both lookup outputs are 0 whatever the lookup address is.
- R5: The index is address bits [OFF_W+IDX_W-1:OFF_W] (bits [5:2] for 16 entries), and the tag is address bits [31:32-TAG_W] (bits [31:16]). The bits between them and the bits below the index do not affect the result.
- R6: A lookup whose tag equals the stored tag, where the stored status is nonzero, returns that status and target on the outputs after the next rising edge.
- R7: A lookup whose tag differs from the stored tag returns status 0 and target 0.
- R8: A stored status of 0 gives outputs of 0 even when the tags match.
- R9: With `updEn` low, the update inputs change no entry.
- R10: A lookup and an update to the same index on the same edge return the old contents. A lookup on the following edge returns the new contents.
- R11: An update to an index replaces the whole entry, so the previous tag at that index no longer hits.
- R12: A second reset clears every entry again, so entries that hit before the reset return zeros afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| lookupPc | input | ADDR_W | Address to look up |
| hitStatus | output | 2 | Registered status of a hit, else 0 |
| hitTarget | output | TGT_W | Registered target of a hit, else 0 |
| updEn | input | 1 | Write the entry selected by `updPc` |
| updPc | input | ADDR_W | Address that supplies the update index and tag |
| updStatus | input | 2 | Status to store |
| updTarget | input | TGT_W | Target to store |
| ready | output | 1 | High once the clearing sweep has finished |

## Verification
Two functions can land on the same clock edge: a lookup read and an update write to the same index. In a second pair, the sweep and an outside update both compete for the one write port. The bench provokes the first pair by presenting a lookup and an update of one index in the same cycle. It expects the old entry first and the new entry one edge later. The bench provokes the second pair by holding an update valid throughout the sweep. It judges the result afterwards, when a lookup of that address must return zeros.

// File: rtl/bttPkg.sv
package bttPkg;

  typedef enum logic {
    PH_SWEEP = 1'b0,
    PH_SERVE = 1'b1
  } phase_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic sweepWr;    // write port owned by the clearing sweep
    logic gateLookup; // force lookup outputs to zero
    logic acceptUpd;  // external updates may use the write port
  } ctrlStrobes_t;

endpackage

// File: rtl/bttClearCtrl.sv
module bttClearCtrl
  import bttPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] sweepIdx,
  output logic             ready
);

  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(DEPTH - 1);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_SWEEP;
      sweepIdx <= '0;
    end else if (phase == PH_SWEEP) begin
      sweepIdx <= sweepIdx + 1'b1;
      if (sweepIdx == LastIdx) begin
        phase <= PH_SERVE;
      end
    end
  end

  always_comb begin
    strobes.sweepWr    = (phase == PH_SWEEP);
    strobes.gateLookup = (phase == PH_SWEEP);
    strobes.acceptUpd  = (phase == PH_SERVE);
  end

  assign ready = (phase == PH_SERVE);

  // R2: the sweep advances by exactly one entry per clock
  assert_sweep_step_R2: assert property (@(posedge clk) disable iff (rst)
    (strobes.sweepWr && sweepIdx != LastIdx) |=> (sweepIdx == $past(sweepIdx) + 1'b1));

  // R2: ready rises only after the last entry was cleared
  assert_ready_after_last_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(sweepIdx) == LastIdx));

  // R2: once serving, the block never goes back to sweeping without reset
  assert_no_resweep_R2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

endmodule

// File: rtl/bttDatapath.sv
module bttDatapath
  import bttPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 16,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  sweepIdx,
  input  logic [ADDR_W-1:0] lookupPc,
  output logic [1:0]        hitStatus,
  output logic [TGT_W-1:0]  hitTarget,
  input  logic              updEn,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [1:0]        updStatus,
  input  logic [TGT_W-1:0]  updTarget
);

  logic [1:0]       statMem [DEPTH];
  logic [TAG_W-1:0] tagMem  [DEPTH];
  logic [TGT_W-1:0] tgtMem  [DEPTH];

  // Address split
  logic [IDX_W-1:0] lkIdx, upIdx;
  logic [TAG_W-1:0] lkTag, upTag;

  assign lkIdx = lookupPc[OFF_W +: IDX_W];
  assign upIdx = updPc[OFF_W +: IDX_W];
  assign lkTag = lookupPc[ADDR_W-1 -: TAG_W];
  assign upTag = updPc[ADDR_W-1 -: TAG_W];

  // Write-port mux: the sweep owns the port until it finishes
  logic             wrEn;
  logic [IDX_W-1:0] wrIdx;
  logic [1:0]       wrStat;
  logic [TAG_W-1:0] wrTag;
  logic [TGT_W-1:0] wrTgt;

  always_comb begin
    if (strobes.sweepWr) begin
      wrEn   = 1'b1;
      wrIdx  = sweepIdx;
      wrStat = '0;
      wrTag  = '0;
      wrTgt  = '0;
    end else begin
      wrEn   = strobes.acceptUpd & updEn;
      wrIdx  = upIdx;
      wrStat = updStatus;
      wrTag  = upTag;
      wrTgt  = updTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      statMem[wrIdx] <= wrStat;
      tagMem[wrIdx]  <= wrTag;
      tgtMem[wrIdx]  <= wrTgt;
    end
  end

  // Lookup: read the current contents, register the qualified result
  logic [1:0]       rdStat;
  logic [TAG_W-1:0] rdTag;
  logic [TGT_W-1:0] rdTgt;
  logic             lkHit;

  assign rdStat = statMem[lkIdx];
  assign rdTag  = tagMem[lkIdx];
  assign rdTgt  = tgtMem[lkIdx];
  assign lkHit  = (rdTag == lkTag) && (rdStat != 2'b00);

  always_ff @(posedge clk) begin
    if (rst || strobes.gateLookup || !lkHit) begin
      hitStatus <= '0;
      hitTarget <= '0;
    end else begin
      hitStatus <= rdStat;
      hitTarget <= rdTgt;
    end
  end

  // R4: lookups during the sweep give zero outputs
  assert_gated_during_sweep_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.gateLookup |=> (hitStatus == '0 && hitTarget == '0));

  // R8: a zero status never comes with a target
  assert_zero_status_no_target_R8: assert property (@(posedge clk) disable iff (rst)
    (hitStatus == 2'b00) |-> (hitTarget == '0));

  // R3: the control never grants updates while the sweep owns the port
  assert_port_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(strobes.sweepWr && strobes.acceptUpd));

endmodule

// File: rtl/branchTargetTable.sv
module branchTargetTable
  import bttPkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 16,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lookupPc,
  output logic [1:0]        hitStatus,
  output logic [TGT_W-1:0]  hitTarget,
  input  logic              updEn,
  input  logic [ADDR_W-1:0] updPc,
  input  logic [1:0]        updStatus,
  input  logic [TGT_W-1:0]  updTarget,
  output logic              ready
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] sweepIdx;

  bttClearCtrl #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .sweepIdx(sweepIdx),
    .ready   (ready)
  );

  bttDatapath #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .TAG_W (TAG_W),
    .TGT_W (TGT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .sweepIdx (sweepIdx),
    .lookupPc (lookupPc),
    .hitStatus(hitStatus),
    .hitTarget(hitTarget),
    .updEn    (updEn),
    .updPc    (updPc),
    .updStatus(updStatus),
    .updTarget(updTarget)
  );

endmodule

// File: tb/branchTargetTable_bench.sv
module branchTargetTable_bench;

  localparam int BD = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] lookupPc;
  logic [1:0]  hitStatus;
  logic [31:0] hitTarget;
  logic        updEn;
  logic [31:0] updPc;
  logic [1:0]  updStatus;
  logic [31:0] updTarget;
  logic        ready;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  logic [1:0]  mStat [BD];
  logic [15:0] mTag  [BD];
  logic [31:0] mTgt  [BD];

  always #10 clk = ~clk;

  branchTargetTable #(.DEPTH(BD)) u_branchTargetTable (
    .clk(clk), .rst(rst), .lookupPc(lookupPc), .hitStatus(hitStatus),
    .hitTarget(hitTarget), .updEn(updEn), .updPc(updPc),
    .updStatus(updStatus), .updTarget(updTarget), .ready(ready)
  );

  function automatic logic [31:0] mkPc(int idx, logic [15:0] tag, int mid);
    return {tag, 10'(mid), 4'(idx), 2'b01};
  endfunction

  function automatic logic [15:0] tagOf(int i);
    return 16'(i * 37 + 11);
  endfunction

  function automatic logic [31:0] tgtOf(int i);
    return 32'h1000_0000 + 32'(i) * 32'h0004_0104;
  endfunction

  function automatic logic [33:0] expect_(logic [31:0] pc);
    int idx;
    idx = int'((pc >> 2) % BD);
    if (mTag[idx] == pc[31:16] && mStat[idx] != 2'b00)
      return {mStat[idx], mTgt[idx]};
    return 34'd0;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < BD; i++) begin
      mStat[i] = '0; mTag[i] = '0; mTgt[i] = '0;
    end
  endtask

  task automatic check(string req, logic [33:0] act, logic [33:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got status %0d target %h, expected status %0d target %h",
               req, act[33:32], act[31:0], exp[33:32], exp[31:0]);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %b, expected %b", req, act, exp);
    end
  endtask

  // Lookup: drive at a falling edge, check at the next falling edge
  task automatic lookup(string req, logic [31:0] pc);
    lookupPc = pc;
    @(negedge clk);
    check(req, {hitStatus, hitTarget}, expect_(pc));
  endtask

  task automatic write(logic [31:0] pc, logic [1:0] st, logic [31:0] tg);
    updEn = 1'b1; updPc = pc; updStatus = st; updTarget = tg;
    @(negedge clk);
    updEn = 1'b0;
    mStat[(pc >> 2) % BD] = st;
    mTag[(pc >> 2) % BD]  = pc[31:16];
    mTgt[(pc >> 2) % BD]  = tg;
  endtask

  task automatic resetAndSweep(bit withUpd);
    rst = 1'b1;
    updEn = withUpd; updPc = mkPc(5, 16'hABCD, 3); updStatus = 2'd3; updTarget = 32'hCAFE_0005;
    lookupPc = mkPc(5, 16'hABCD, 3);
    repeat (2) @(negedge clk);
    checkBit("R1 ready in reset", ready, 1'b0);
    check("R1 outputs in reset", {hitStatus, hitTarget}, 34'd0);
    rst = 1'b0;
    for (int cyc = 1; cyc <= BD; cyc++) begin
      @(negedge clk);
      if (cyc < BD) begin
        checkBit("R2 ready low during sweep", ready, 1'b0);
        check("R4 outputs zero during sweep", {hitStatus, hitTarget}, 34'd0);
      end else begin
        checkBit("R2 ready after sweep", ready, 1'b1);
      end
    end
    updEn = 1'b0;
    clearModel();
  endtask

  initial begin
    rst = 1'b1; updEn = 1'b0; updPc = '0; updStatus = '0; updTarget = '0; lookupPc = '0;
    @(negedge clk);

    // R1 R2 R4 and R3: updates held throughout the sweep are dropped
    resetAndSweep(1'b1);
    lookup("R3 update during sweep ignored", mkPc(5, 16'hABCD, 3));

    // Fill every entry; status cycles through 0..3
    for (int i = 0; i < BD; i++) write(mkPc(i, tagOf(i), i * 7), 2'(i % 4), tgtOf(i));

    for (int i = 0; i < BD; i++) begin
      lookup((i % 4 == 0) ? "R8 zero status no hit" : "R6 tag match hit",
             mkPc(i, tagOf(i), 1023 - i));
      lookup("R7 tag mismatch", mkPc(i, tagOf(i) ^ 16'h0100, 0));
      lookup("R5 unused bits ignored", mkPc(i, tagOf(i), 5) | 32'h2);
    end

    // R9: enable low changes nothing
    updEn = 1'b0; updPc = mkPc(1, 16'h7777, 0); updStatus = 2'd3; updTarget = 32'hDEAD_0001;
    @(negedge clk);
    lookup("R9 disabled update keeps entry", mkPc(1, tagOf(1), 0));
    lookup("R9 disabled update tag no hit", mkPc(1, 16'h7777, 0));

    // R10: same-cycle lookup and update of one index
    lookupPc = mkPc(2, tagOf(2), 0);
    updEn = 1'b1; updPc = mkPc(2, tagOf(2), 9); updStatus = 2'd1; updTarget = 32'h0BAD_F00D;
    @(negedge clk);
    updEn = 1'b0;
    check("R10 old contents on collision", {hitStatus, hitTarget}, expect_(mkPc(2, tagOf(2), 0)));
    mStat[2] = 2'd1; mTgt[2] = 32'h0BAD_F00D;
    lookup("R10 new contents next edge", mkPc(2, tagOf(2), 0));
    check("R10 new value explicit", {hitStatus, hitTarget}, {2'd1, 32'h0BAD_F00D});

    // R11: aliasing at one index replaces the entry
    write(mkPc(3, 16'h5A5A, 0), 2'd2, 32'h1234_5678);
    lookup("R11 old tag evicted", mkPc(3, tagOf(3), 0));
    lookup("R11 new tag hits", mkPc(3, 16'h5A5A, 44));

    // R12: a second reset wipes every entry
    resetAndSweep(1'b0);
    for (int i = 0; i < BD; i++) begin
      lookupPc = mkPc(i, (i == 3) ? 16'h5A5A : tagOf(i), 0);
      @(negedge clk);
      check("R12 entry cleared by second reset", {hitStatus, hitTarget}, 34'd0);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testCnt++; failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule